// File: doc/BRIEF.md
# Oversampling Serial Receiver with Symbol Stream Output

This block receives characters from an asynchronous serial line. It runs on the system clock and times each bit with a counter. It detects the start bit, samples every following bit near its centre and assembles the data bits, least significant bit first. It then checks the optional parity bit and the stop bit. Each good character is placed in a one-entry holding register and offered on a valid/ready stream. The register keeps the character until the consumer takes it.

A 16-bit configuration word sets the bit timing and the parity mode. The block copies this word only while its synchronous reset is high, so software changes it only while the receiver is held in reset. Two flag outputs report problems, each as a single-cycle pulse. `overflow` reports a character lost because the previous one was still waiting. `error` reports a character dropped because of a parity or framing fault.

Top module: `uart_rx_phy`

## Requirements
- R1: While `rst` is high the receiver is idle and `sym_valid` is low, and any symbol still pending when reset is asserted is dropped. After reset is released, `sym_valid` stays low until a new character arrives.
- R2: The configuration word is copied only while `rst` is high. Changing `cfg` while `rst` is low has no effect on how characters are received.
- R3: A received character appears on `sym_data` with `sym_valid` high. Both stay unchanged until a cycle in which `sym_ready` is also high, and that cycle consumes the symbol.
- R4: If a character completes while the held symbol is valid and `sym_ready` is low, `overflow` is high for exactly one cycle. The new character is discarded and the held symbol is kept unchanged.
- R5: `cfg[14:13]` selects the parity: 00 is none, 01 is even, 10 is odd, and 11 is treated as none. With even parity the data bits and the parity bit together contain an even number of ones; with odd parity they contain an odd number. A parity mismatch makes `error` high for exactly one cycle, and the character is not delivered.
- R6: If the stop bit is sampled low, `error` is high for exactly one cycle and the character is not delivered.
- R7: `cfg[12:0]` gives the bit period in clock cycles. Values below 4 are treated as 4.
- R8: A frame has one low start bit, eight data bits sent least significant bit first, the parity bit if one is enabled, and one high stop bit. Each bit is sampled at mid-period after a two-flop synchronizer.
- R9: If the line is high again when the start bit is re-checked at half a bit period, the receiver returns to idle. In that case no symbol is delivered and no error is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset; the configuration is copied while it is high |
| cfg | input | 16 | Configuration word: bit period in [12:0], parity in [14:13], [15] reserved |
| rx_pin | input | 1 | Asynchronous serial input; the idle level is high |
| sym_data | output | 8 | Payload of the received character |
| sym_valid | output | 1 | A symbol is held and offered |
| sym_ready | input | 1 | The consumer accepts the symbol in this cycle |
| overflow | output | 1 | One-cycle pulse: a character was lost because the previous symbol was still pending |
| error | output | 1 | One-cycle pulse: a parity or stop-bit fault was seen |

## Verification
The bench targets the following corner cases.
- Two characters arrive back to back with no read in between. A design that overwrote the held symbol would return the second byte instead of the first.
- A short low glitch ends before the half-bit re-check. A design that skipped the re-check would deliver a spurious byte or raise `error`.
- Bad parity and a low stop bit. A design that got these wrong would deliver the faulty byte, or would stretch or miss the `error` pulse.
- Configuration changes while reset is low, and divisor values below the minimum. A design that sampled the word all the time would lose bit timing in the middle of the stream, and one that did not clamp the divisor would sample far too early.

Random frames with random divisors and parity modes are checked against a bench function that computes the expected parity.

// File: rtl/uart_rx_phy.sv
module uart_rx_phy #(
  parameter int CFG_W   = 16,
  parameter int SYM_W   = 8,
  parameter int DIV_W   = 13,
  parameter int MIN_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  input  logic             rx_pin,
  output logic [SYM_W-1:0] sym_data,
  output logic             sym_valid,
  input  logic             sym_ready,
  output logic             overflow,
  output logic             error
);
  localparam int IDX_W = (SYM_W > 1) ? $clog2(SYM_W) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SYM_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic [CFG_W-1:0] cfg_q;
  logic [2:0]       sync_q;
  st_t              st;
  logic [DIV_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [SYM_W-1:0] shreg;
  logic             par_acc;

  always_ff @(posedge clk)
    if (rst) cfg_q <= cfg;

  wire [DIV_W-1:0] div_raw = cfg_q[DIV_W-1:0];
  wire [DIV_W-1:0] div     = (div_raw < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_raw;
  wire [1:0]       pmode   = cfg_q[DIV_W+1:DIV_W];
  wire             par_en  = (pmode == 2'b01) || (pmode == 2'b10);
  wire             line    = sync_q[1];
  wire             fall    = sync_q[2] & ~sync_q[1];
  wire             tick    = (cnt == '0);

  always_ff @(posedge clk)
    if (rst) sync_q <= 3'b111;
    else     sync_q <= {sync_q[1:0], rx_pin};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      idx       <= '0;
      shreg     <= '0;
      par_acc   <= 1'b0;
      sym_valid <= 1'b0;
      sym_data  <= '0;
      overflow  <= 1'b0;
      error     <= 1'b0;
    end else begin
      overflow <= 1'b0;
      error    <= 1'b0;
      if (sym_valid && sym_ready) sym_valid <= 1'b0;
      case (st)
        S_IDLE:
          if (fall) begin
            st  <= S_START;
            cnt <= (div >> 1) - 1'b1;
          end
        S_START:
          if (tick) begin
            if (!line) begin
              st      <= S_DATA;
              cnt     <= div - 1'b1;
              idx     <= '0;
              par_acc <= (pmode == 2'b10);
            end else begin
              st <= S_IDLE;
            end
          end else cnt <= cnt - 1'b1;
        S_DATA:
          if (tick) begin
            shreg   <= {line, shreg[SYM_W-1:1]};
            par_acc <= par_acc ^ line;
            cnt     <= div - 1'b1;
            idx     <= idx + 1'b1;
            if (idx == IDX_LAST) st <= par_en ? S_PAR : S_STOP;
          end else cnt <= cnt - 1'b1;
        S_PAR:
          if (tick) begin
            par_acc <= par_acc ^ line;
            cnt     <= div - 1'b1;
            st      <= S_STOP;
          end else cnt <= cnt - 1'b1;
        S_STOP:
          if (tick) begin
            st <= S_IDLE;
            if (!line || (par_en && par_acc)) begin
              error <= 1'b1;
            end else if (sym_valid && !sym_ready) begin
              overflow <= 1'b1;
            end else begin
              sym_valid <= 1'b1;
              sym_data  <= shreg;
            end
          end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_data)));

  assert_ovf_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (sym_valid && $stable(sym_data)));

  assert_ovf_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    overflow |=> !overflow);

  assert_err_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    error |=> !error);

  assert_err_no_load_R6: assert property (@(posedge clk) disable iff (rst)
    (error && !$past(sym_valid)) |-> !sym_valid);

  assert_flags_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(error && overflow));
endmodule

// File: tb/sim_uart_rx_phy.sv
module sim_uart_rx_phy;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_i = 16'd16;
  logic        rx_i = 1'b1;
  logic        rdy_i = 1'b0;
  logic [7:0]  sym_data;
  logic        sym_valid, overflow, error;

  int tests = 0, fails = 0;
  int err_n = 0, ovf_n = 0, wide_n = 0;
  logic err_prev = 1'b0, ovf_prev = 1'b0;

  always #5 clk = ~clk;

  uart_rx_phy u0 (
    .clk(clk), .rst(rst), .cfg(cfg_i), .rx_pin(rx_i),
    .sym_data(sym_data), .sym_valid(sym_valid), .sym_ready(rdy_i),
    .overflow(overflow), .error(error)
  );

  always @(negedge clk) begin
    if (error) err_n++;
    if (overflow) ovf_n++;
    if ((error && err_prev) || (overflow && ovf_prev)) wide_n++;
    err_prev = error;
    ovf_prev = overflow;
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic par_bit(input logic [7:0] d, input int pm);
    return (pm == 1) ? ^d : ~^d;
  endfunction

  task automatic do_reset(input logic [15:0] c);
    @(negedge clk);
    rst = 1'b1; cfg_i = c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic hold_bit(input logic v, input int div);
    rx_i = v;
    repeat (div) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int div, input int pm,
                      input bit flip, input bit bad_stop);
    hold_bit(1'b0, div);
    for (int i = 0; i < 8; i++) hold_bit(d[i], div);
    if (pm == 1 || pm == 2) hold_bit(par_bit(d, pm) ^ flip, div);
    hold_bit(!bad_stop, div);
    hold_bit(1'b1, 2 * div);
  endtask

  task automatic consume;
    @(negedge clk); rdy_i = 1'b1;
    @(negedge clk); rdy_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int e0, o0;
    void'($urandom(32'h5eed_1234));
    do_reset(16'd16);
    chk("R1 reset valid", sym_valid, 0);
    chk("R1 reset flags", error | overflow, 0);

    send(8'hA5, 16, 0, 0, 0);
    chk("R8 valid after frame", sym_valid, 1);
    chk("R8 lsb-first data", sym_data, 8'hA5);
    repeat (20) @(negedge clk);
    chk("R3 held valid", sym_valid, 1);
    chk("R3 held data", sym_data, 8'hA5);
    consume();
    chk("R3 consumed", sym_valid, 0);

    o0 = ovf_n;
    send(8'h3C, 16, 0, 0, 0);
    send(8'h81, 16, 0, 0, 0);
    chk("R4 overflow pulses", ovf_n - o0, 1);
    chk("R4 old symbol kept", sym_data, 8'h3C);
    consume();
    chk("R4 new symbol discarded", sym_valid, 0);

    do_reset(16'h2010);
    e0 = err_n;
    send(8'h07, 16, 1, 0, 0);
    chk("R5 even parity ok", sym_data, 8'h07);
    consume();
    send(8'h07, 16, 1, 1, 0);
    chk("R5 even parity bad err", err_n - e0, 1);
    chk("R5 bad parity not delivered", sym_valid, 0);
    do_reset(16'h4010);
    send(8'h5A, 16, 2, 0, 0);
    chk("R5 odd parity ok", sym_data, 8'h5A);
    consume();

    do_reset(16'd16);
    e0 = err_n;
    send(8'hC3, 16, 0, 0, 1);
    chk("R6 framing err", err_n - e0, 1);
    chk("R6 framing not delivered", sym_valid, 0);

    e0 = err_n;
    hold_bit(1'b0, 3);
    hold_bit(1'b1, 40);
    chk("R9 glitch no symbol", sym_valid, 0);
    chk("R9 glitch no error", err_n - e0, 0);
    send(8'h66, 16, 0, 0, 0);
    chk("R9 frame after glitch", sym_data, 8'h66);

    send(8'h11, 16, 0, 0, 0);
    consume();
    consume();
    @(negedge clk); rst = 1'b1;
    send(8'h22, 16, 0, 0, 0);
    chk("R1 no reception in reset", sym_valid, 0);
    rst = 1'b0;
    send(8'h99, 16, 0, 0, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 pending dropped", sym_valid, 0);

    cfg_i = 16'h4005;
    send(8'hE1, 16, 0, 0, 0);
    chk("R2 cfg ignored outside reset", sym_data, 8'hE1);
    chk("R2 cfg ignored valid", sym_valid, 1);
    consume();

    do_reset(16'd1);
    send(8'hB7, 4, 0, 0, 0);
    chk("R7 divisor clamp", sym_data, 8'hB7);
    consume();

    for (int k = 0; k < 40; k++) begin
      int div, pm;
      logic [7:0] d;
      bit flip;
      div  = 4 + int'($urandom % 21);
      pm   = int'($urandom % 4);
      d    = 8'($urandom);
      flip = (pm == 1 || pm == 2) && ($urandom % 4 == 0);
      do_reset({1'b0, 2'(pm), 13'(div)});
      e0 = err_n;
      send(d, div, pm, flip, 0);
      if (flip) begin
        chk("R5 random bad parity", {err_n - e0, 31'(sym_valid)}, {32'd1, 31'd0});
      end else begin
        chk("R8 random frame", {31'(sym_valid), 8'(sym_data), err_n - e0}, {31'd1, d, 32'd0});
        consume();
      end
    end

    chk("R4 R5 pulse width one cycle", wide_n, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule